// File: doc/BRIEF.md
# Line-Crossing Load/Store Splitter

This block sits between a single load/store requester and two line banks of 16-byte (128-bit) lines. Lines with address bit 4 clear live in the even bank and lines with bit 4 set live in the odd bank. Any access that runs past the end of its line goes to both banks in the same cycle. The block gives each bank the line index, a 16-bit lane mask and lane-aligned store data. It then combines the two bank handshakes into one accept, one exception and one load-complete signal for the requester. On the return path it joins the two returned lines and realigns the requested bytes to bit 0.

The requester holds `up_valid_i` and the request fields steady until it sees completion. For a store, completion is the address accept. For a load, completion is the load-complete pulse. For either kind, an exception also ends the request. The requester must then drop `up_valid_i` for at least one cycle before it starts the next request. A bank signals acceptance of a pending sub-request with a one-cycle `bank_addr_ok_i` or `bank_addr_exc_i`. For a load, the bank later returns its line with a one-cycle `bank_ld_ok_i`. The two banks may respond in any order and in any cycles.

Top module: `ldst_line_splitter`

## Requirements
- R1: The first line is line index `addr[47:4]` and goes to the bank selected by `addr[4]` (0 = even = bank 0, 1 = odd = bank 1). When the access spills past byte 15, the other bank receives line index + 1.
- R2: The length code `up_len_i` selects 1 << code bytes: 1, 2, 4 or 8. Bytes `addr[3:0]` up to `addr[3:0]`+n-1 are enabled. Offsets below 16 set that lane in the first bank's mask. Offsets of 16 and above set lane offset-16 in the second bank's mask. The second bank is issued a sub-request only when at least one of its lanes is enabled.
- R3: Store byte k (bits 8k+7:8k) appears on lane (`addr[3:0]`+k) mod 16 of the bank that owns that offset. All lanes outside the mask carry zero, whatever the upper store-data bits hold.
- R4: `bank_valid_o[b]` is high from the first cycle of a request, for each bank the request needs, until the cycle in which that bank accepts. From the next cycle it stays low for the rest of the request.
- R5: `up_addr_ok_o` pulses for exactly one cycle. The pulse comes in the cycle in which the last needed bank accepts, whether the other needed bank accepted earlier or in the same cycle.
- R6: An exception from a pending needed bank gives a one-cycle `up_addr_exc_o` in that cycle. After it, that request sees no `up_addr_ok_o` and no `up_ld_ok_o`, and every bank's valid is low from the next cycle. An exception on a bank the request does not need has no effect.
- R7: For a load, `up_ld_ok_o` pulses for one cycle in the cycle the last needed bank returns its line. The pulse is never earlier than the overall address accept. `up_ld_data_o` holds memory byte `addr`+k in bits 8k+7:8k, with bytes taken from whichever bank returned them and in whichever cycle.
- R8: Load result bytes at positions n and above are zero.
- R9: During reset, and while `up_valid_i` is low, all bank valids and all three requester pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| up_valid_i | input | 1 | Request active; held until completion |
| up_is_st_i | input | 1 | 1 = store, 0 = load |
| up_addr_i | input | 48 | Byte address |
| up_len_i | input | 2 | Length code, 1 << code bytes |
| up_st_data_i | input | 64 | Store data, byte 0 in bits 7:0 |
| up_addr_ok_o | output | 1 | Address accepted by every needed bank (pulse) |
| up_addr_exc_o | output | 1 | Request cannot complete (pulse) |
| up_ld_ok_o | output | 1 | Load data valid (pulse) |
| up_ld_data_o | output | 64 | Realigned load data |
| bank_valid_o | output | 2 | Sub-request pending, per bank |
| bank_is_st_o | output | 2 | Sub-request is a store, per bank |
| bank_line_o | output | 2x44 | Line index, per bank |
| bank_be_o | output | 2x16 | Lane enables, per bank |
| bank_st_data_o | output | 2x128 | Lane-aligned store data, per bank |
| bank_addr_ok_i | input | 2 | Bank accepts its sub-request (pulse) |
| bank_addr_exc_i | input | 2 | Bank rejects its sub-request (pulse) |
| bank_ld_ok_i | input | 2 | Bank returns its line (pulse) |
| bank_ld_data_i | input | 2x128 | Returned line data, per bank |

## Verification
The bench drives spills from either bank into the other, including a wrap from line 15 into line 16. If the bank-select or the +1 was wrong, the line check or the memory read-back would give the wrong bytes. The bench also skews the two banks' accept and return cycles in both directions. A design without sticky per-bank state would then pulse too early, pulse twice, or lose the half that returned first. Exceptions are injected on the first bank, on the second bank after the first has already accepted, and on a bank the access never touches. A design that got cancellation wrong would still report accept or load-complete, or would leave the other bank's valid high. A design that did not gate by need would raise a spurious exception.

// File: rtl/ldst_split_pkg.sv
package ldst_split_pkg;
  localparam int unsigned NUM_BANKS = 2;
  typedef enum logic {BANK_EVEN = 1'b0, BANK_ODD = 1'b1} bank_e;
endpackage

// File: rtl/ldst_lane_map.sv
module ldst_lane_map #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned LEN_W      = 2
) (
  input  logic [$clog2(LINE_BYTES)-1:0] off_i,
  input  logic [LEN_W-1:0]              len_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [LINE_BYTES-1:0]         be_lo_o,
  output logic [LINE_BYTES-1:0]         be_hi_o,
  output logic [LINE_BYTES*8-1:0]       dat_lo_o,
  output logic [LINE_BYTES*8-1:0]       dat_hi_o,
  output logic [DATA_W/8-1:0]           keep_o
);
  localparam int unsigned MAX_B  = DATA_W / 8;
  localparam int unsigned LINE_W = LINE_BYTES * 8;
  localparam int unsigned PAIR_B = 2 * LINE_BYTES;

  logic [PAIR_B-1:0]   keep_wide;
  logic [PAIR_B-1:0]   mask;
  logic [DATA_W-1:0]   dat_m;
  logic [2*LINE_W-1:0] dat_wide;

  always_comb begin
    for (int i = 0; i < PAIR_B; i++)
      keep_wide[i] = (i < (1 << len_i)) && (i < MAX_B);
    mask = keep_wide << off_i;
    for (int i = 0; i < MAX_B; i++)
      dat_m[8*i +: 8] = keep_wide[i] ? data_i[8*i +: 8] : 8'h00;
    dat_wide = {{(2*LINE_W-DATA_W){1'b0}}, dat_m} << {off_i, 3'b000};
  end

  assign be_lo_o  = mask[LINE_BYTES-1:0];
  assign be_hi_o  = mask[PAIR_B-1:LINE_BYTES];
  assign dat_lo_o = dat_wide[LINE_W-1:0];
  assign dat_hi_o = dat_wide[2*LINE_W-1:LINE_W];
  assign keep_o   = keep_wide[MAX_B-1:0];
endmodule

// File: rtl/ldst_bank_track.sv
module ldst_bank_track #(
  parameter int unsigned LINE_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              need_i,
  input  logic              abort_i,
  input  logic              addr_ok_i,
  input  logic              ld_ok_i,
  input  logic [LINE_W-1:0] ld_data_i,
  output logic              valid_o,
  output logic              acc_now_o,
  output logic              ret_now_o,
  output logic [LINE_W-1:0] data_o
);
  logic              acc_q, ret_q;
  logic [LINE_W-1:0] held_q;
  logic              take_acc, take_ret;

  assign valid_o   = active_i & need_i & ~acc_q & ~abort_i;
  assign take_acc  = valid_o & addr_ok_i;
  // data is only taken from a bank that has accepted (now or earlier)
  assign take_ret  = active_i & need_i & ld_ok_i & (acc_q | take_acc);
  assign acc_now_o = ~need_i | acc_q | take_acc;
  assign ret_now_o = ~need_i | ret_q | take_ret;
  assign data_o    = take_ret ? ld_data_i : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= 1'b0;
      ret_q  <= 1'b0;
      held_q <= '0;
    end else if (!active_i) begin
      acc_q <= 1'b0;
      ret_q <= 1'b0;
    end else begin
      if (take_acc) acc_q <= 1'b1;
      if (take_ret) begin
        ret_q  <= 1'b1;
        held_q <= ld_data_i;
      end
    end
  end

  assert_valid_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && addr_ok_i && active_i) |=> !valid_o);
  assert_ret_needs_acc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_q |-> acc_q);
endmodule

// File: rtl/ldst_ld_merge.sv
module ldst_ld_merge #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LINE_BYTES = 16
) (
  input  logic                               first_i,
  input  logic [$clog2(LINE_BYTES)-1:0]      off_i,
  input  logic [DATA_W/8-1:0]                keep_i,
  input  logic [1:0][LINE_BYTES*8-1:0]       half_i,
  output logic [DATA_W-1:0]                  data_o
);
  localparam int unsigned LINE_W = LINE_BYTES * 8;
  logic [2*LINE_W-1:0] pair;

  always_comb begin
    pair = {half_i[~first_i], half_i[first_i]} >> {off_i, 3'b000};
    for (int i = 0; i < DATA_W/8; i++)
      data_o[8*i +: 8] = keep_i[i] ? pair[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/ldst_line_splitter.sv
module ldst_line_splitter
  import ldst_split_pkg::*;
#(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned LEN_W      = 2
) (
  input  logic                                                 clk_i,
  input  logic                                                 rst_ni,
  input  logic                                                 up_valid_i,
  input  logic                                                 up_is_st_i,
  input  logic [ADDR_W-1:0]                                    up_addr_i,
  input  logic [LEN_W-1:0]                                     up_len_i,
  input  logic [DATA_W-1:0]                                    up_st_data_i,
  output logic                                                 up_addr_ok_o,
  output logic                                                 up_addr_exc_o,
  output logic                                                 up_ld_ok_o,
  output logic [DATA_W-1:0]                                    up_ld_data_o,
  output logic [NUM_BANKS-1:0]                                 bank_valid_o,
  output logic [NUM_BANKS-1:0]                                 bank_is_st_o,
  output logic [NUM_BANKS-1:0][ADDR_W-$clog2(LINE_BYTES)-1:0]  bank_line_o,
  output logic [NUM_BANKS-1:0][LINE_BYTES-1:0]                 bank_be_o,
  output logic [NUM_BANKS-1:0][LINE_BYTES*8-1:0]               bank_st_data_o,
  input  logic [NUM_BANKS-1:0]                                 bank_addr_ok_i,
  input  logic [NUM_BANKS-1:0]                                 bank_addr_exc_i,
  input  logic [NUM_BANKS-1:0]                                 bank_ld_ok_i,
  input  logic [NUM_BANKS-1:0][LINE_BYTES*8-1:0]               bank_ld_data_i
);
  localparam int unsigned OFF_W   = $clog2(LINE_BYTES);
  localparam int unsigned LINE_W  = LINE_BYTES * 8;
  localparam int unsigned LINE_AW = ADDR_W - OFF_W;

  logic [OFF_W-1:0]      off;
  bank_e                 first_bank;
  logic [LINE_AW-1:0]    line;
  logic [LINE_BYTES-1:0] be_lo, be_hi;
  logic [LINE_W-1:0]     dat_lo, dat_hi;
  logic [DATA_W/8-1:0]   keep;
  logic [NUM_BANKS-1:0]  need, acc_now, ret_now;
  logic [NUM_BANKS-1:0][LINE_W-1:0] half;
  logic                  addr_done_q, ld_done_q, abort_q;
  logic                  live, exc_now;

  assign off        = up_addr_i[OFF_W-1:0];
  assign first_bank = bank_e'(up_addr_i[OFF_W]);
  assign line       = up_addr_i[ADDR_W-1:OFF_W];

  ldst_lane_map #(.DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)) i_lane_map (
    .off_i   (off),
    .len_i   (up_len_i),
    .data_i  (up_st_data_i),
    .be_lo_o (be_lo),
    .be_hi_o (be_hi),
    .dat_lo_o(dat_lo),
    .dat_hi_o(dat_hi),
    .keep_o  (keep)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam bank_e BANK_ID = bank_e'(b);
    logic is_first;
    assign is_first          = (first_bank == BANK_ID);
    assign need[b]           = is_first | (|be_hi);
    assign bank_is_st_o[b]   = up_is_st_i;
    assign bank_line_o[b]    = is_first ? line : line + 1'b1;
    assign bank_be_o[b]      = is_first ? be_lo : be_hi;
    assign bank_st_data_o[b] = is_first ? dat_lo : dat_hi;

    ldst_bank_track #(.LINE_W(LINE_W)) i_track (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (up_valid_i),
      .need_i   (need[b]),
      .abort_i  (abort_q),
      .addr_ok_i(bank_addr_ok_i[b]),
      .ld_ok_i  (bank_ld_ok_i[b]),
      .ld_data_i(bank_ld_data_i[b]),
      .valid_o  (bank_valid_o[b]),
      .acc_now_o(acc_now[b]),
      .ret_now_o(ret_now[b]),
      .data_o   (half[b])
    );
  end

  ldst_ld_merge #(.DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) i_ld_merge (
    .first_i(up_addr_i[OFF_W]),
    .off_i  (off),
    .keep_i (keep),
    .half_i (half),
    .data_o (up_ld_data_o)
  );

  assign live          = up_valid_i & ~abort_q;
  assign exc_now       = live & ~addr_done_q & |(bank_valid_o & bank_addr_exc_i);
  assign up_addr_exc_o = exc_now;
  assign up_addr_ok_o  = live & ~addr_done_q & ~exc_now & (&acc_now);
  assign up_ld_ok_o    = live & ~up_is_st_i & ~ld_done_q & ~exc_now & (&acc_now) & (&ret_now);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_done_q <= 1'b0;
      ld_done_q   <= 1'b0;
      abort_q     <= 1'b0;
    end else if (!up_valid_i) begin
      addr_done_q <= 1'b0;
      ld_done_q   <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      if (up_addr_ok_o)  addr_done_q <= 1'b1;
      if (up_ld_ok_o)    ld_done_q   <= 1'b1;
      if (up_addr_exc_o) abort_q     <= 1'b1;
    end
  end

  assert_ok_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_addr_ok_o |=> !up_addr_ok_o);
  assert_exc_silences_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_addr_exc_o |=> !(up_addr_ok_o || up_ld_ok_o));
  assert_exc_cancels_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_addr_exc_o |=> (bank_valid_o == '0));
  assert_ld_after_ok_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_ld_ok_o |-> (addr_done_q || up_addr_ok_o));
  assert_ld_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_ld_ok_o |=> !up_ld_ok_o);
endmodule

// File: tb/test_ldst_line_splitter.sv
`timescale 1ns/1ps
module test_ldst_line_splitter;
  localparam int EV_OK = 0, EV_EXC = 1, EV_LD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              up_valid = 0, up_is_st = 0;
  logic [47:0]       up_addr = '0;
  logic [1:0]        up_len = '0;
  logic [63:0]       up_st_data = '0;
  logic              up_addr_ok, up_addr_exc, up_ld_ok;
  logic [63:0]       up_ld_data;
  logic [1:0]        bank_valid, bank_is_st;
  logic [1:0][43:0]  bank_line;
  logic [1:0][15:0]  bank_be;
  logic [1:0][127:0] bank_st_data;
  logic [1:0]        bank_addr_ok = '0, bank_addr_exc = '0, bank_ld_ok = '0;
  logic [1:0][127:0] bank_ld_data = '0;

  ldst_line_splitter i_ldst_line_splitter (
    .clk_i(clk), .rst_ni(rst_n),
    .up_valid_i(up_valid), .up_is_st_i(up_is_st), .up_addr_i(up_addr),
    .up_len_i(up_len), .up_st_data_i(up_st_data),
    .up_addr_ok_o(up_addr_ok), .up_addr_exc_o(up_addr_exc),
    .up_ld_ok_o(up_ld_ok), .up_ld_data_o(up_ld_data),
    .bank_valid_o(bank_valid), .bank_is_st_o(bank_is_st), .bank_line_o(bank_line),
    .bank_be_o(bank_be), .bank_st_data_o(bank_st_data),
    .bank_addr_ok_i(bank_addr_ok), .bank_addr_exc_i(bank_addr_exc),
    .bank_ld_ok_i(bank_ld_ok), .bank_ld_data_i(bank_ld_data)
  );

  typedef struct { int kind; logic [63:0] data; } ev_t;
  ev_t q[$];
  int n_checks = 0, n_fail = 0;
  logic [7:0] mem [256];
  logic [1:0] cfg_exc = '0;
  int cfg_acc [2] = '{0, 0};
  int cfg_ld  [2] = '{0, 0};

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bank model: memory of 256 bytes, index = line[3:0]*16 + lane
  task automatic responder(input int b);
    logic [3:0]   ln;
    logic [15:0]  be;
    logic [127:0] sd, rd;
    logic         st;
    forever begin
      @(negedge clk);
      if (rst_n && bank_valid[b]) begin
        ln = bank_line[b][3:0]; be = bank_be[b]; sd = bank_st_data[b]; st = bank_is_st[b];
        repeat (cfg_acc[b]) @(posedge clk);
        @(posedge clk); #1;
        if (!bank_valid[b]) continue;
        if (cfg_exc[b]) begin
          bank_addr_exc[b] = 1'b1;
          @(posedge clk); #1;
          bank_addr_exc[b] = 1'b0;
          continue;
        end
        for (int l = 0; l < 16; l++) rd[8*l +: 8] = mem[{ln, l[3:0]}];
        if (st) for (int l = 0; l < 16; l++) if (be[l]) mem[{ln, l[3:0]}] = sd[8*l +: 8];
        bank_addr_ok[b] = 1'b1;
        if (!st && cfg_ld[b] == 0) begin bank_ld_ok[b] = 1'b1; bank_ld_data[b] = rd; end
        @(posedge clk); #1;
        bank_addr_ok[b] = 1'b0; bank_ld_ok[b] = 1'b0;
        if (!st && cfg_ld[b] > 0) begin
          for (int i = 1; i < cfg_ld[b]; i++) begin @(posedge clk); #1; end
          bank_ld_ok[b] = 1'b1; bank_ld_data[b] = rd;
          @(posedge clk); #1;
          bank_ld_ok[b] = 1'b0;
        end
      end
    end
  endtask

  initial responder(0);
  initial responder(1);

  task automatic take(input int kind, input logic [63:0] data);
    ev_t e;
    string tag;
    tag = (kind == EV_OK) ? "R5 accept" : (kind == EV_EXC) ? "R6 exception" : "R7/R8 load data";
    n_checks++;
    if (q.size() == 0) begin
      n_fail++;
      $display("FAIL %s unexpected pulse act=%0d exp=none", tag, kind);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || (kind == EV_LD && e.data !== data)) begin
        n_fail++;
        $display("FAIL %s act=%0d/%h exp=%0d/%h", tag, kind, data, e.kind, e.data);
      end
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (up_addr_exc) take(EV_EXC, '0);
      if (up_addr_ok)  take(EV_OK, '0);
      if (up_ld_ok)    take(EV_LD, up_ld_data);
    end
  end

  task automatic access(input bit st, input logic [47:0] addr, input logic [1:0] len,
                        input logic [63:0] data, input logic [1:0] exc,
                        input int a0, input int a1, input int l0, input int l1);
    int n, off, f, bk, lane, absb;
    logic [1:0] need;
    logic [1:0][15:0] ebe;
    logic [1:0][127:0] esd;
    logic [1:0][43:0] eln;
    logic [63:0] eld;
    ev_t e;
    n = 1 << len; off = int'(addr[3:0]); f = int'(addr[4]);
    ebe = '0; esd = '0; eld = '0; need = '0; need[f] = 1'b1;
    eln[f] = addr[47:4]; eln[1-f] = addr[47:4] + 44'd1;
    for (int k = 0; k < n; k++) begin
      absb = off + k;
      bk = (absb < 16) ? f : 1 - f;
      lane = absb % 16;
      need[bk] = 1'b1;
      ebe[bk][lane] = 1'b1;
      esd[bk][8*lane +: 8] = data[8*k +: 8];
      eld[8*k +: 8] = mem[8'(addr + 48'(k))];
    end
    cfg_exc = exc; cfg_acc = '{a0, a1}; cfg_ld = '{l0, l1};
    if (|(exc & need)) begin
      e.kind = EV_EXC; e.data = '0; q.push_back(e);
    end else begin
      e.kind = EV_OK; e.data = '0; q.push_back(e);
      if (!st) begin e.kind = EV_LD; e.data = eld; q.push_back(e); end
    end
    @(posedge clk); #1;
    up_valid = 1'b1; up_is_st = st; up_addr = addr; up_len = len; up_st_data = data;
    @(negedge clk);
    chk(bank_valid == need, "R2/R4 bank valids", 128'(bank_valid), 128'(need));
    for (int b = 0; b < 2; b++) if (need[b]) begin
      chk(bank_line[b] == eln[b], "R1 line index", 128'(bank_line[b]), 128'(eln[b]));
      chk(bank_be[b] == ebe[b], "R2 lane mask", 128'(bank_be[b]), 128'(ebe[b]));
      if (st) chk(bank_st_data[b] == esd[b], "R3 store lanes", bank_st_data[b], esd[b]);
    end
    do @(negedge clk); while (!(up_addr_exc || (st ? up_addr_ok : up_ld_ok)));
    @(negedge clk);
    chk(bank_valid == 2'b00, "R4/R6 valids low after end", 128'(bank_valid), 128'(0));
    @(posedge clk); #1;
    up_valid = 1'b0;
    @(negedge clk);
    chk({bank_valid, up_addr_ok, up_addr_exc, up_ld_ok} == '0, "R9 idle quiet",
        128'({bank_valid, up_addr_ok, up_addr_exc, up_ld_ok}), 128'(0));
    repeat (8) @(posedge clk);
  endtask

  bit done = 0;
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 29 + 7);
    repeat (3) @(negedge clk);
    chk({bank_valid, up_addr_ok, up_addr_exc, up_ld_ok} == '0, "R9 reset quiet",
        128'({bank_valid, up_addr_ok, up_addr_exc, up_ld_ok}), 128'(0));
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    access(1, 48'h20, 2'd3, 64'h1122_3344_5566_7788, 2'b00, 0, 0, 0, 0); // R1 even aligned store
    access(1, 48'h1F, 2'd1, 64'hAAAA_BBBB_CCCC_DDEE, 2'b00, 1, 0, 0, 0); // R3 odd->even spill, junk masked
    access(0, 48'h20, 2'd3, '0, 2'b00, 0, 0, 0, 0);                      // R7 read back
    access(0, 48'h1C, 2'd3, '0, 2'b00, 0, 2, 0, 3);                      // R5/R7 skewed halves
    access(0, 48'h0E, 2'd2, '0, 2'b00, 2, 0, 3, 0);                      // R1 even->odd spill
    access(0, 48'h35, 2'd0, '0, 2'b00, 1, 1, 1, 1);                      // R8 single byte zero-fill
    access(1, 48'h3E, 2'd2, 64'hDEAD_BEEF_0BAD_F00D, 2'b00, 2, 0, 0, 0); // R2 spill store
    access(0, 48'h3A, 2'd3, '0, 2'b00, 1, 1, 2, 0);                      // R7 same-cycle accept
    access(0, 48'h4C, 2'd3, '0, 2'b10, 0, 2, 0, 0);                      // R6 exc on second bank
    access(1, 48'h5D, 2'd2, 64'h0123_4567_89AB_CDEF, 2'b10, 3, 0, 0, 0); // R6 exc on first bank cancels
    access(1, 48'h40, 2'd0, 64'h55, 2'b10, 0, 0, 0, 0);                  // R6 unneeded bank exc ignored
    access(0, 48'hFF, 2'd3, '0, 2'b00, 0, 1, 1, 0);                      // R1 line 15 -> 16 wrap
    access(0, 48'h1F, 2'd1, '0, 2'b00, 0, 0, 0, 0);                      // R3 read back spill store
    access(0, 48'h5D, 2'd2, '0, 2'b00, 0, 0, 0, 0);                      // R6 canceled store left memory alone
    repeat (4) @(posedge clk);
    chk(q.size() == 0, "R5/R7 missing pulses", 128'(q.size()), 128'(0));
    finish_run();
  end
endmodule